// File: doc/BRIEF.md
# Chained Instruction Watchpoint Pair

This block holds two hardware watchpoint units that watch the instruction fetch stream and raise a breakpoint request when a fetch matches what a debugger has programmed. Each unit keeps an address value and an address mask, plus a control value and a control mask. A mask bit of 1 makes the matching bit a don't-care. The control word is matched against live qualifiers of the fetch: the instruction-set state, the user or privileged indicator, a per-unit external condition, a chain input and a range input. Bit 8 of the control value is an enable. It has no mask bit, and it decides whether a match is allowed to raise the request.

Unit 1 can steer unit 0 in two ways. The first is a chain latch that unit 1 loads when its own address and control both match. The latch takes the unit's data-match input, and it is cleared by a write to that unit's control value or by reset. The second is unit 1's raw address-match output, which unit 0 sees on the same fetch. With these, a debugger can ask for "break at X only after Y has been fetched" or "break only while the address lies inside unit 1's window". Registers are written through a plain write port: a unit select, a register select and a data word.

Top module: `fetch_wp_pair`

## Requirements
- R1: While `rst_n` is low, `brk_req` is 0, all registers are 0 and both chain latches are 0. A chain latch that was set before reset reads as 0 once reset has been released.
- R2: A unit's address field matches when `(fetch_addr ^ addr_value) & ~addr_mask` is zero. A mask bit of 1 is a don't-care.
- R3: Control bit 1 is compared with `fetch_compact` (1 means compact-encoding fetch, 0 means standard fetch), unless control-mask bit 1 is set.
- R4: Control bit 4 is compared with `fetch_priv` (0 means user-mode fetch, 1 means privileged fetch), unless control-mask bit 4 is set.
- R5: Control bit 5 of unit n is compared with `ext_cond[n]`, unless control-mask bit 5 is set.
- R6: Each unit has a chain latch. When `fetch_valid` is high and the unit matches on both address and control, the latch loads `data_hit[n]` at the clock edge. Otherwise it holds its value. Control bit 6 of unit 0 is compared with the value unit 1's latch held before that fetch. Unit 1's bit 6 is compared with 0.
- R7: A write to a unit's control value (`cfg_sel` = 2) clears that unit's chain latch, and this takes priority over a load on the same cycle.
- R8: Control bit 7 of unit 0 is compared with unit 1's address match on the same fetch. Unit 1's bit 7 is compared with 0.
- R9: Control-value bit 8 is the enable. A unit whose enable is 0 never raises `brk_req`. The control mask is 8 bits wide, so writing bit 8 of the mask has no effect. Control bits 0, 2 and 3 are never compared.
- R10: `brk_req` is registered. It shows, one cycle later, the result of a cycle where `fetch_valid` was high. After a cycle with `fetch_valid` low it is 0, whatever the other inputs are.
- R11: `brk_req` is the OR of the enabled matches of both units.
- R12: Register select codes on `cfg_sel` are: 0 address value, 1 address mask, 2 control value (`cfg_wdata[8:0]`), 3 control mask (`cfg_wdata[7:0]`). `cfg_unit` picks the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also clears the chain latches |
| cfg_we | input | 1 | Register write strobe |
| cfg_unit | input | 1 | Unit addressed by the write |
| cfg_sel | input | 2 | Register addressed by the write |
| cfg_wdata | input | 32 | Write data |
| fetch_valid | input | 1 | An instruction fetch is presented this cycle |
| fetch_addr | input | 32 | Fetch address |
| fetch_compact | input | 1 | Instruction-set state of the fetch |
| fetch_priv | input | 1 | Privileged fetch indicator |
| ext_cond | input | 2 | External condition, one bit per unit |
| data_hit | input | 2 | Data-match value loaded into each unit's chain latch |
| brk_req | output | 1 | Registered breakpoint request |

## Verification
Directed fetches isolate one control field at a time. All other fields are masked, so a hit or miss can only come from the field under test: address mask, instruction-set state, privilege, external input, or the enable with a mask write that tries to cover it. The chain sequence fetches unit 1's address with `data_hit` low and then high, followed by unrelated fetches. This separates a latch that arms on the right fetch from one that takes effect too early, and a latch that holds from one that decays. Control-value writes and a reset pulse then show whether the latch is cleared. Range fetches inside and outside unit 1's window show that the range input follows the same fetch. Random fetches over a small address space, with random reprogramming, then mix every field against a bench model of both units.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    parameter int ADDR_W    = 32;
    parameter int CTRL_W    = 9;
    parameter int NUM_UNITS = 2;

    localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
    localparam int CMSK_W = CTRL_W - 1;

    // control word bit positions
    localparam int CB_ISA   = 1;
    localparam int CB_PRIV  = 4;
    localparam int CB_EXT   = 5;
    localparam int CB_CHAIN = 6;
    localparam int CB_RANGE = 7;
    localparam int CB_EN    = 8;

    localparam logic [CMSK_W-1:0] CTRL_LIVE = CMSK_W'((1 << CB_ISA) | (1 << CB_PRIV) |
                                                      (1 << CB_EXT) | (1 << CB_CHAIN) |
                                                      (1 << CB_RANGE));

    typedef enum logic [1:0] {
        SEL_AVAL = 2'd0,
        SEL_AMSK = 2'd1,
        SEL_CVAL = 2'd2,
        SEL_CMSK = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] aval;
        logic [ADDR_W-1:0] amsk;
        logic [CTRL_W-1:0] cval;
        logic [CMSK_W-1:0] cmsk;
    } unit_regs_t;

endpackage

// File: rtl/fwp_field_match.sv
module fwp_field_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] msk,
    input  logic [W-1:0] act,
    output logic         hit
);

    // mask bit set means don't care
    assign hit = ~|((val ^ act) & ~msk);

endmodule

// File: rtl/fwp_unit.sv
module fwp_unit
    import fwp_pkg::*;
(
    input  unit_regs_t        regs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              compact,
    input  logic              priv,
    input  logic              ext,
    input  logic              chain_in,
    input  logic              range_in,
    output logic              addr_hit,
    output logic              unit_hit,
    output logic              enabled
);

    logic [CMSK_W-1:0] ctrl_act;
    logic [CMSK_W-1:0] ctrl_dc;
    logic              ctrl_hit;

    always_comb begin
        ctrl_act           = '0;
        ctrl_act[CB_ISA]   = compact;
        ctrl_act[CB_PRIV]  = priv;
        ctrl_act[CB_EXT]   = ext;
        ctrl_act[CB_CHAIN] = chain_in;
        ctrl_act[CB_RANGE] = range_in;
    end

    // bits with no qualifier behind them are never compared
    assign ctrl_dc = regs.cmsk | ~CTRL_LIVE;

    fwp_field_match #(.W(ADDR_W)) i_addr_cmp (
        .val (regs.aval),
        .msk (regs.amsk),
        .act (addr),
        .hit (addr_hit)
    );

    fwp_field_match #(.W(CMSK_W)) i_ctrl_cmp (
        .val (regs.cval[CMSK_W-1:0]),
        .msk (ctrl_dc),
        .act (ctrl_act),
        .hit (ctrl_hit)
    );

    assign unit_hit = addr_hit & ctrl_hit;
    assign enabled  = regs.cval[CB_EN];

endmodule

// File: rtl/fetch_wp_pair.sv
module fetch_wp_pair
    import fwp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [UNIT_W-1:0]    cfg_unit,
    input  logic [1:0]           cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic                 fetch_valid,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 fetch_compact,
    input  logic                 fetch_priv,
    input  logic [NUM_UNITS-1:0] ext_cond,
    input  logic [NUM_UNITS-1:0] data_hit,
    output logic                 brk_req
);

    typedef struct packed {
        unit_regs_t [NUM_UNITS-1:0] regs;
        logic       [NUM_UNITS-1:0] chain;
        logic                       brk;
    } wp_state_t;

    wp_state_t st_d, st_q;

    logic [NUM_UNITS-1:0] addr_hit;
    logic [NUM_UNITS-1:0] unit_hit;
    logic [NUM_UNITS-1:0] unit_en;
    logic [NUM_UNITS-1:0] chain_in;
    logic [NUM_UNITS-1:0] range_in;
    logic [NUM_UNITS-1:0] chain_q;

    assign chain_q = st_q.chain;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        if (u + 1 < NUM_UNITS) begin : g_fed
            // the next unit up arms this one
            assign chain_in[u] = st_q.chain[u+1];
            assign range_in[u] = addr_hit[u+1];
        end else begin : g_last
            assign chain_in[u] = 1'b0;
            assign range_in[u] = 1'b0;
        end

        fwp_unit i_unit (
            .regs     (st_q.regs[u]),
            .addr     (fetch_addr),
            .compact  (fetch_compact),
            .priv     (fetch_priv),
            .ext      (ext_cond[u]),
            .chain_in (chain_in[u]),
            .range_in (range_in[u]),
            .addr_hit (addr_hit[u]),
            .unit_hit (unit_hit[u]),
            .enabled  (unit_en[u])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.brk = fetch_valid & |(unit_hit & unit_en);
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (fetch_valid && unit_hit[u]) begin
                st_d.chain[u] = data_hit[u];
            end
            if (cfg_we && cfg_unit == UNIT_W'(u)) begin
                unique case (cfg_sel_e'(cfg_sel))
                    SEL_AVAL: st_d.regs[u].aval = cfg_wdata;
                    SEL_AMSK: st_d.regs[u].amsk = cfg_wdata;
                    SEL_CVAL: begin
                        st_d.regs[u].cval = cfg_wdata[CTRL_W-1:0];
                        st_d.chain[u]     = 1'b0;
                    end
                    SEL_CMSK: st_d.regs[u].cmsk = cfg_wdata[CMSK_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign brk_req = st_q.brk;

endmodule

// File: rtl/fwp_chk.sv
module fwp_chk
    import fwp_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fetch_valid,
    input logic                 cfg_we,
    input logic [UNIT_W-1:0]    cfg_unit,
    input logic [1:0]           cfg_sel,
    input logic                 brk_req,
    input logic [NUM_UNITS-1:0] unit_hit,
    input logic [NUM_UNITS-1:0] unit_en,
    input logic [NUM_UNITS-1:0] chain_q
);

    localparam int TOP_U = NUM_UNITS - 1;

    logic top_cval_wr;
    assign top_cval_wr = cfg_we && cfg_sel == 2'd2 && cfg_unit == UNIT_W'(TOP_U);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!brk_req && chain_q == '0));

    // R10
    idle_no_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !brk_req);

    // R11
    hit_raises_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && |(unit_hit & unit_en)) |=> brk_req);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en == '0) |=> !brk_req);

    // R7
    chain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_cval_wr |=> !chain_q[TOP_U]);

    // R6
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fetch_valid && unit_hit[TOP_U]) && !top_cval_wr) |=> $stable(chain_q[TOP_U]));

endmodule

bind fetch_wp_pair fwp_chk i_fwp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .cfg_we      (cfg_we),
    .cfg_unit    (cfg_unit),
    .cfg_sel     (cfg_sel),
    .brk_req     (brk_req),
    .unit_hit    (unit_hit),
    .unit_en     (unit_en),
    .chain_q     (chain_q)
);

// File: tb/test_fetch_wp_pair.sv
`timescale 1ns/1ps
module test_fetch_wp_pair;
    import fwp_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [UNIT_W-1:0] cfg_unit = '0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [31:0]       cfg_wdata = 32'h0;
    logic              fetch_valid = 1'b0;
    logic [31:0]       fetch_addr = 32'h0;
    logic              fetch_compact = 1'b0;
    logic              fetch_priv = 1'b0;
    logic [1:0]        ext_cond = 2'b00;
    logic [1:0]        data_hit = 2'b00;
    logic              brk_req;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_av [2];
    logic [31:0] m_am [2];
    logic [8:0]  m_cv [2];
    logic [7:0]  m_cm [2];
    logic        m_ch [2];

    always #2.5 clk = ~clk;

    fetch_wp_pair i_fetch_wp_pair (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_unit      (cfg_unit),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_compact (fetch_compact),
        .fetch_priv    (fetch_priv),
        .ext_cond      (ext_cond),
        .data_hit      (data_hit),
        .brk_req       (brk_req)
    );

    task automatic model_clear();
        for (int u = 0; u < 2; u++) begin
            m_av[u] = '0; m_am[u] = '0; m_cv[u] = '0; m_cm[u] = '0; m_ch[u] = 1'b0;
        end
    endtask

    function automatic logic m_ahit(int u, logic [31:0] a);
        return ((m_av[u] ^ a) & ~m_am[u]) == 32'h0;
    endfunction

    function automatic logic m_chit(int u, logic isa, logic pv, logic ex, logic ch, logic rg);
        logic [7:0] act;
        act    = 8'h00;
        act[1] = isa;
        act[4] = pv;
        act[5] = ex;
        act[6] = ch;
        act[7] = rg;
        return ((m_cv[u][7:0] ^ act) & ~m_cm[u] & 8'hF2) == 8'h00;
    endfunction

    task automatic check(logic act, logic exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: brk_req=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_wr(int u, int sel, logic [31:0] d);
        cfg_we    = 1'b1;
        cfg_unit  = UNIT_W'(u);
        cfg_sel   = sel[1:0];
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_av[u] = d;
            1: m_am[u] = d;
            2: begin m_cv[u] = d[8:0]; m_ch[u] = 1'b0; end
            default: m_cm[u] = d[7:0];
        endcase
        check(brk_req, 1'b0, "R10");
    endtask

    task automatic do_fetch(logic [31:0] a, logic isa, logic pv, logic [1:0] ex,
                            logic [1:0] dh, string req);
        logic h0, h1, exp_b;
        fetch_addr    = a;
        fetch_compact = isa;
        fetch_priv    = pv;
        ext_cond      = ex;
        data_hit      = dh;
        fetch_valid   = 1'b1;
        h1    = m_ahit(1, a) && m_chit(1, isa, pv, ex[1], 1'b0, 1'b0);
        h0    = m_ahit(0, a) && m_chit(0, isa, pv, ex[0], m_ch[1], m_ahit(1, a));
        exp_b = (h0 && m_cv[0][8]) || (h1 && m_cv[1][8]);
        if (h1) m_ch[1] = dh[1];
        if (h0) m_ch[0] = dh[0];
        @(negedge clk);
        fetch_valid = 1'b0;
        check(brk_req, exp_b, req);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd7321));
        model_clear();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(brk_req, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(brk_req, 1'b0, "R1");

        // R2 address mask
        do_wr(0, 0, 32'h1000_0040);
        do_wr(0, 1, 32'h0000_000F);
        do_wr(0, 3, 32'h0000_00FF);
        do_wr(0, 2, 32'h0000_0100);
        do_fetch(32'h1000_004C, 0, 0, 2'b00, 2'b00, "R2");
        do_fetch(32'h1000_0050, 0, 0, 2'b00, 2'b00, "R2");
        do_fetch(32'h1000_0040, 1, 1, 2'b11, 2'b00, "R2");

        // R3 instruction-set state
        do_wr(0, 3, 32'h0000_00FD);
        do_wr(0, 2, 32'h0000_0102);
        do_fetch(32'h1000_0041, 1, 0, 2'b00, 2'b00, "R3");
        do_fetch(32'h1000_0041, 0, 0, 2'b00, 2'b00, "R3");

        // R4 privilege
        do_wr(0, 3, 32'h0000_00EF);
        do_wr(0, 2, 32'h0000_0110);
        do_fetch(32'h1000_0042, 0, 1, 2'b00, 2'b00, "R4");
        do_fetch(32'h1000_0042, 0, 0, 2'b00, 2'b00, "R4");
        do_wr(0, 2, 32'h0000_0100);
        do_fetch(32'h1000_0042, 0, 0, 2'b00, 2'b00, "R4");
        do_fetch(32'h1000_0042, 0, 1, 2'b00, 2'b00, "R4");

        // R5 per-unit external condition
        do_wr(0, 3, 32'h0000_00DF);
        do_wr(0, 2, 32'h0000_0120);
        do_fetch(32'h1000_0043, 0, 0, 2'b10, 2'b00, "R5");
        do_fetch(32'h1000_0043, 0, 0, 2'b01, 2'b00, "R5");

        // R9 enable off, mask bit 8 cannot cover it
        do_wr(0, 3, 32'h0000_01FF);
        do_wr(0, 2, 32'h0000_0000);
        do_fetch(32'h1000_0043, 0, 0, 2'b00, 2'b00, "R9");
        do_wr(0, 2, 32'h0000_000D);
        do_fetch(32'h1000_0044, 0, 0, 2'b00, 2'b00, "R9");
        do_wr(0, 2, 32'h0000_010D);
        do_fetch(32'h1000_0044, 0, 0, 2'b00, 2'b00, "R9");

        // R10 matching inputs without fetch_valid
        fetch_addr = 32'h1000_0044;
        @(negedge clk);
        check(brk_req, 1'b0, "R10");

        // R8 range from unit 1 address window
        do_wr(1, 0, 32'h2000_0000);
        do_wr(1, 1, 32'h0000_0FFF);
        do_wr(1, 3, 32'h0000_00FF);
        do_wr(1, 2, 32'h0000_0000);
        do_wr(0, 1, 32'hFFFF_FFFF);
        do_wr(0, 3, 32'h0000_007F);
        do_wr(0, 2, 32'h0000_0180);
        do_fetch(32'h2000_0123, 0, 0, 2'b00, 2'b00, "R8");
        do_fetch(32'h3000_0000, 0, 0, 2'b00, 2'b00, "R8");

        // R6 chain latch
        do_wr(1, 0, 32'h4000_0000);
        do_wr(1, 1, 32'h0000_0000);
        do_wr(0, 3, 32'h0000_00BF);
        do_wr(0, 2, 32'h0000_0140);
        do_fetch(32'h0000_5000, 0, 0, 2'b00, 2'b00, "R6");
        do_fetch(32'h4000_0000, 0, 0, 2'b00, 2'b00, "R6");
        do_fetch(32'h0000_5000, 0, 0, 2'b00, 2'b00, "R6");
        do_fetch(32'h4000_0000, 0, 0, 2'b00, 2'b10, "R6");
        do_fetch(32'h0000_5000, 0, 0, 2'b00, 2'b00, "R6");
        do_fetch(32'h0000_5004, 0, 0, 2'b00, 2'b00, "R6");
        do_fetch(32'h4000_0000, 0, 0, 2'b00, 2'b00, "R6");
        do_fetch(32'h0000_5000, 0, 0, 2'b00, 2'b00, "R6");

        // R7 control-value write clears the latch
        do_fetch(32'h4000_0000, 0, 0, 2'b00, 2'b10, "R7");
        do_fetch(32'h0000_5000, 0, 0, 2'b00, 2'b00, "R7");
        do_wr(1, 2, 32'h0000_0000);
        do_fetch(32'h0000_5000, 0, 0, 2'b00, 2'b00, "R7");

        // R11 both units enabled
        do_wr(0, 1, 32'h0000_0000);
        do_wr(0, 3, 32'h0000_00FF);
        do_wr(0, 0, 32'h0000_0A00);
        do_wr(1, 2, 32'h0000_0100);
        do_fetch(32'h0000_0A00, 0, 0, 2'b00, 2'b00, "R11");
        do_fetch(32'h4000_0000, 0, 0, 2'b00, 2'b00, "R11");
        do_fetch(32'h0000_0B00, 0, 0, 2'b00, 2'b00, "R11");

        // R1 reset clears an armed chain latch
        do_wr(1, 2, 32'h0000_0000);
        do_fetch(32'h4000_0000, 0, 0, 2'b00, 2'b10, "R1");
        rst_n = 1'b0;
        @(negedge clk);
        check(brk_req, 1'b0, "R1");
        rst_n = 1'b1;
        model_clear();
        do_wr(0, 1, 32'hFFFF_FFFF);
        do_wr(0, 3, 32'h0000_00BF);
        do_wr(0, 2, 32'h0000_0140);
        do_fetch(32'h0000_5000, 0, 0, 2'b00, 2'b00, "R1");

        // R12 random programming and fetches against the model
        for (int i = 0; i < 600; i++) begin
            r = $urandom % 10;
            if (r < 2) begin
                int u;
                int sel;
                u   = int'($urandom % 2);
                sel = int'($urandom % 4);
                case (sel)
                    0: do_wr(u, sel, $urandom & 32'h0000_00FF);
                    1: do_wr(u, sel, $urandom & 32'h0000_00F3);
                    2: do_wr(u, sel, $urandom & 32'h0000_01FF);
                    default: do_wr(u, sel, $urandom & 32'h0000_01FF);
                endcase
            end else begin
                r = $urandom;
                do_fetch($urandom & 32'h0000_00FF, r[0], r[1], r[3:2], r[5:4], "R12");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule